// File: doc/BRIEF.md
# Serial Port Interrupt Source Selector

This block produces the single CPU interrupt of one direction (receive or transmit) of a serial port. A 2-bit source field picks which event raises it: each new data element (the ready bit going high), the end of a subframe, a frame-sync pulse seen on the external pin, or a frame-synchronization error. Subframe counting and sync-error detection are done elsewhere. They arrive here as a strobe and a flag.

The output is a one-cycle pulse in the CPU clock domain. The frame-sync pin is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector, so each sync pulse gives exactly one interrupt. The frame-sync source keeps working while the port section is held in reset. The other three sources are muted during that reset. The sync-error flag is not consumed here, so software can still read it when the interrupt comes from another source.

The source field is held in a small state register, one state per source. A new field value is taken on the next clock. A change of source never raises an interrupt by itself.

Top module: `sio_irq_sel`

## Requirements
- R1: While `rst_n` is low, `irq` is 0. The source state after reset is per-element (code 00), whatever value `mode` carries, until the first clock edge after reset is released.
- R2: In source 00 (per-element), a 0-to-1 change of `rdy` sampled at a clock edge gives `irq` = 1 for exactly the following cycle.
- R3: In source 00, `rdy` held high gives no further pulse after the first.
- R4: In source 01 (end of subframe), every cycle with `subfr_end` high gives `irq` = 1 in the following cycle, including back-to-back strobes.
- R5: In source 10 (frame sync), a rising edge of `fsync_pin` gives one `irq` pulse on the third clock edge after the pin is first sampled high. This is true for long and for single-cycle pin pulses.
- R6: Source 10 still produces its pulse while `sect_rst` is high.
- R7: In source 11 (sync error), a 0-to-1 change of `sync_err` gives one `irq` pulse in the following cycle. The flag held high gives no further pulse.
- R8: While `sect_rst` is high, sources 00, 01 and 11 produce no pulse. An edge of `rdy` or `sync_err` that happens during that time is not saved for later.
- R9: A new `mode` value selects the source from the next clock edge. Switching sources gives no pulse, even when the newly selected level input is already high.
- R10: A rise of `sync_err` while the source is not 11 leaves `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Device reset, asynchronous, active low |
| sect_rst | input | 1 | Reset of this port direction, active high |
| mode | input | 2 | Interrupt source field: 00 element, 01 subframe end, 10 frame sync, 11 sync error |
| rdy | input | 1 | Data-ready status bit |
| subfr_end | input | 1 | One-cycle strobe at the end of each subframe |
| fsync_pin | input | 1 | External frame-sync pin, asynchronous to `clk` |
| sync_err | input | 1 | Frame-synchronization error flag |
| irq | output | 1 | Interrupt pulse, one cycle wide |

## Verification
The bench checks that a level does not re-fire. A design that sends `rdy` or `sync_err` straight to the output would hold `irq` high for many cycles. It checks that the frame-sync pulse arrives exactly three edges after the pin rises. A synchronizer with the wrong depth, or one with no edge detector, would move or stretch that pulse. It also checks that frame-sync interrupts continue during `sect_rst`, which would be lost if the section reset gated every source. Finally, it checks that switching sources while a level is high stays silent. A design whose edge detectors only run for the selected source would raise a false interrupt there.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int unsigned MODE_W = 2;

    // Interrupt source states; the encoding equals the software field value
    typedef enum logic [MODE_W-1:0] {
        SRC_ELEM  = 2'b00,
        SRC_SUBFR = 2'b01,
        SRC_FSYNC = 2'b10,
        SRC_SERR  = 2'b11
    } src_e;

endpackage

// File: rtl/sio_fs_sync.sv
module sio_fs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);
    localparam int unsigned LAST = STAGES;

    // chain[STAGES-1:0] are the synchronizer flops, chain[LAST] is the edge history
    logic [LAST:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("sio_fs_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[LAST-1:0], pin_async};
        end
    end

    assign rise = chain[LAST-1] & ~chain[LAST];

endmodule

// File: rtl/sio_rise_det.sv
module sio_rise_det #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/sio_src_fsm.sv
module sio_src_fsm
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              sect_rst,
    input  logic              elem_rise,
    input  logic              subfr_end,
    input  logic              fs_rise,
    input  logic              serr_rise,
    output src_e              state_o,
    output logic              irq
);
    src_e state_q;
    src_e state_d;
    logic irq_d;

    // Every state moves to the state the field names; no transition fires an event
    always_comb begin
        state_d = src_e'(mode_req);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_ELEM;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode for the current state
    always_comb begin
        irq_d = 1'b0;
        unique case (state_q)
            SRC_ELEM:  irq_d = elem_rise & ~sect_rst;
            SRC_SUBFR: irq_d = subfr_end & ~sect_rst;
            SRC_FSYNC: irq_d = fs_rise;
            SRC_SERR:  irq_d = serr_rise & ~sect_rst;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= irq_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/sio_irq_sel.sv
module sio_irq_sel
    import sio_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sect_rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              rdy,
    input  logic              subfr_end,
    input  logic              fsync_pin,
    input  logic              sync_err,
    output logic              irq
);
    localparam int unsigned LVL_W = 2;

    logic [LVL_W-1:0] lvl_rise;
    logic             fs_rise;
    src_e             src_q;

    // Level edges run in every state so that a source switch finds current history
    sio_rise_det #(.W(LVL_W)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({sync_err, rdy}),
        .rise  (lvl_rise)
    );

    sio_fs_sync #(.STAGES(SYNC_STAGES)) u_fs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (fsync_pin),
        .rise      (fs_rise)
    );

    sio_src_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (mode),
        .sect_rst  (sect_rst),
        .elem_rise (lvl_rise[0]),
        .subfr_end (subfr_end),
        .fs_rise   (fs_rise),
        .serr_rise (lvl_rise[1]),
        .state_o   (src_q),
        .irq       (irq)
    );

endmodule

// File: rtl/sio_irq_sel_chk.sv
module sio_irq_sel_chk
    import sio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sect_rst,
    input logic [MODE_W-1:0] mode,
    input logic              rdy,
    input logic              subfr_end,
    input logic              sync_err,
    input logic              irq,
    input src_e              state
);
    logic up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (irq == 1'b0); // R1
    end

    AST_ELEM_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && state == SRC_ELEM && rdy && !$past(rdy) && !sect_rst) |=> irq); // R2

    AST_ELEM_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && state == SRC_ELEM && rdy && $past(rdy)) |=> !irq); // R3

    AST_SUBFR_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_SUBFR && subfr_end && !sect_rst) |=> irq); // R4

    AST_SERR_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && state == SRC_SERR && sync_err && !$past(sync_err) && !sect_rst) |=> irq); // R7

    AST_SECT_RST_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_rst && state != SRC_FSYNC) |=> !irq); // R8

    AST_MODE_NEXT_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> (state == src_e'($past(mode)))); // R9

endmodule

bind sio_irq_sel sio_irq_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sect_rst  (sect_rst),
    .mode      (mode),
    .rdy       (rdy),
    .subfr_end (subfr_end),
    .sync_err  (sync_err),
    .irq       (irq),
    .state     (src_q)
);

// File: tb/sim_sio_irq_sel.sv
`timescale 1ns/1ps
module sim_sio_irq_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sect_rst = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       rdy = 1'b0;
    logic       subfr_end = 1'b0;
    logic       fsync_pin = 1'b0;
    logic       sync_err = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sio_irq_sel u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sect_rst  (sect_rst),
        .mode      (mode),
        .rdy       (rdy),
        .subfr_end (subfr_end),
        .fsync_pin (fsync_pin),
        .sync_err  (sync_err),
        .irq       (irq)
    );

    // Bits: [7:6] mode, [5] rdy, [4] subfr_end, [3] fsync_pin, [2] sync_err, [1] sect_rst, [0] expected irq after the edge
    localparam int NVEC = 21;
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b00_1_0_0_0_0_1, //  0 R2 rdy rises
        8'b00_1_0_0_0_0_0, //  1 R3 held high
        8'b00_0_0_0_0_0_0, //  2 R2 falling edge silent
        8'b00_1_0_0_0_1_0, //  3 R8 rise under section reset
        8'b01_0_0_0_0_0_0, //  4 R9 switch to 01
        8'b01_0_1_0_0_0_1, //  5 R4 subframe strobe
        8'b01_1_0_0_0_0_0, //  6 R4 rdy ignored in 01
        8'b01_1_1_0_0_1_0, //  7 R8 strobe under section reset
        8'b11_1_0_0_0_0_0, //  8 R9 switch to 11
        8'b11_1_0_0_1_0_1, //  9 R7 error rises
        8'b11_1_0_0_1_0_0, // 10 R7 held high
        8'b10_1_0_0_0_0_0, // 11 R9 switch to 10
        8'b10_1_0_1_0_1_0, // 12 R6 pin sampled
        8'b10_1_0_1_0_1_0, // 13 R5 second stage
        8'b10_1_0_1_0_1_1, // 14 R6 fires under section reset
        8'b10_1_0_1_0_0_0, // 15 R5 one pulse only
        8'b10_1_0_0_0_0_0, // 16 R5 pin low
        8'b00_1_0_0_0_0_0, // 17 R9 switch to 00 with rdy high
        8'b00_1_0_0_0_0_0, // 18 R9 no pulse after switch
        8'b00_1_0_0_1_0_0, // 19 R10 error rise in 00
        8'b00_0_0_0_0_0_0  // 20 R10 quiet
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: irq=%0b expected %0b", tag, got, exp);
        end
    endtask

    initial begin
        // Reset state (R1)
        tick();
        chk(irq, 1'b0, "R1 in reset");
        tick();
        chk(irq, 1'b0, "R1 in reset second cycle");
        rst_n = 1'b1;
        tick();
        chk(irq, 1'b0, "R1 after release, idle");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            mode      = VEC[i][7:6];
            rdy       = VEC[i][5];
            subfr_end = VEC[i][4];
            fsync_pin = VEC[i][3];
            sync_err  = VEC[i][2];
            sect_rst  = VEC[i][1];
            tick();
            chk(irq, VEC[i][0], $sformatf("vector %0d", i));
        end

        // R1: default source is per-element whatever the field holds
        rst_n = 1'b0;
        tick();
        chk(irq, 1'b0, "R1 reset reasserted");
        mode = 2'b01;
        rdy  = 1'b1;
        tick();
        chk(irq, 1'b0, "R1 quiet with rdy high in reset");
        rst_n = 1'b1;
        tick();
        chk(irq, 1'b1, "R1 first edge uses source 00");

        // R4: back-to-back subframe strobes
        subfr_end = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(irq, 1'b1, $sformatf("R4 back-to-back strobe %0d", k));
        end
        subfr_end = 1'b0;
        tick();
        chk(irq, 1'b0, "R4 strobe removed");

        // R5: frame-sync latency, long pulse
        mode = 2'b10;
        tick();
        chk(irq, 1'b0, "R9 switch to 10 silent");
        fsync_pin = 1'b1;
        tick();
        chk(irq, 1'b0, "R5 edge 1");
        tick();
        chk(irq, 1'b0, "R5 edge 2");
        tick();
        chk(irq, 1'b1, "R5 edge 3");
        fsync_pin = 1'b0;
        tick();
        chk(irq, 1'b0, "R5 single pulse");
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(irq, 1'b0, "R5 idle");
        end

        // R5: one-cycle pin pulse
        fsync_pin = 1'b1;
        tick();
        chk(irq, 1'b0, "R5 short edge 1");
        fsync_pin = 1'b0;
        tick();
        chk(irq, 1'b0, "R5 short edge 2");
        tick();
        chk(irq, 1'b1, "R5 short edge 3");
        tick();
        chk(irq, 1'b0, "R5 short done");

        // R8: an edge seen under section reset is not saved
        mode = 2'b00;
        rdy  = 1'b0;
        tick();
        tick();
        sect_rst = 1'b1;
        rdy = 1'b1;
        tick();
        chk(irq, 1'b0, "R8 rise muted");
        sect_rst = 1'b0;
        tick();
        chk(irq, 1'b0, "R8 no late pulse");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule